// File: doc/BRIEF.md
# Single-to-Brain-Float Rounding Converter

This block narrows IEEE-754 single-precision words to the 16-bit brain-float format. The sign and the exponent field are kept at their full width and the fraction is cut from 23 to 7 bits. Finite values, whether zero, subnormal or normal, are rounded to nearest with ties to even. The rounding carry can run into the exponent, so a value can move up a binade or overflow to infinity. Infinities pass through unchanged. A NaN stays a NaN even when its only nonzero payload bits are among those dropped.

Data enters and leaves on a single valid/ready stream lane. One register stage sits between the rounding logic and the output. While the consumer stalls, the stage keeps its word, and it takes a new input whenever it is empty or is being drained in the same cycle.

Top module: `f32_to_bf16_conv`

## Requirements
- R1: For an input whose exponent field (bits 30:23) is not all ones, the result is bits 31:16 of the input, plus one when the dropped low 16 bits are above 0x8000. Below 0x8000 the result is bits 31:16 unchanged.
- R2: When the dropped low 16 bits equal exactly 0x8000, the kept 16 bits are incremented only if input bit 16 is 1, which gives ties to even.
- R3: An increment of a kept 7-bit fraction of 0x7F wraps it to 0x00 and adds one to the exponent field. For example, subnormal 0x007F8000 becomes 0x0080.
- R4: The largest finite magnitudes that round up become infinity of the same sign: 0x7F7FFFFF gives 0x7F80 and 0xFF7F8000 gives 0xFF80.
- R5: An infinity input (exponent all ones, fraction zero) gives 0x7F80 or 0xFF80, with the sign kept.
- R6: A NaN input (exponent all ones, fraction nonzero) is not rounded. Its result is bits 31:16 of the input, with bit 0 of the result set when any of the low 16 input bits is nonzero, so the result is always a NaN and a quiet bit (input bit 22) is kept.
- R7: The sign bit of the result always equals input bit 31. Positive zero gives 0x0000 and negative zero gives 0x8000.
- R8: After synchronous reset out_valid is low. A word accepted on a clock edge (in_valid and in_ready high) appears on out_data with out_valid high after that same edge, and out_valid falls after a transfer when no new word is accepted.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R10: in_ready is high exactly when out_ready is high or the output stage is empty.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_data | input | 32 | Single-precision input word |
| out_valid | output | 1 | Converted word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 16 | Brain-float result |

## Verification
The embedded properties assume that in_data is a defined word whenever in_valid is high and that the producer sees in_ready before it counts a word as transferred. They make no assumption about in_data while in_valid is low. The stimulus always drives a full 32-bit value with every valid beat and changes inputs only between clock edges. It steers random words toward the all-ones and 0xFE exponents and the 0x8000 tie pattern, so that the special-value properties and the carry paths are actually triggered under random stalls.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;
  localparam int EXP_W      = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_FRAC_W = 7;
  localparam int SRC_W      = 1 + EXP_W + SRC_FRAC_W;
  localparam int DST_W      = 1 + EXP_W + DST_FRAC_W;
  localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;

  typedef struct packed {
    logic special;  // exponent all ones: Inf or NaN
    logic low_nz;   // any discarded bit set
  } cvt_class_t;
endpackage

// File: rtl/bf16_classify.sv
module bf16_classify #(
  parameter int EXP_W      = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DROP_W     = 16,
  localparam int SRC_W     = 1 + EXP_W + SRC_FRAC_W
) (
  input  logic [SRC_W-1:0]          word,
  output bf16_cvt_pkg::cvt_class_t  cls
);
  logic [EXP_W-1:0]  exp_field;
  logic [DROP_W-1:0] low_field;

  always_comb begin
    exp_field   = word[SRC_W-2 -: EXP_W];
    low_field   = word[DROP_W-1:0];
    cls.special = &exp_field;
    cls.low_nz  = |low_field;
  end
endmodule

// File: rtl/bf16_round.sv
module bf16_round #(
  parameter int EXP_W      = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DST_FRAC_W = 7,
  localparam int SRC_W     = 1 + EXP_W + SRC_FRAC_W,
  localparam int DST_W     = 1 + EXP_W + DST_FRAC_W,
  localparam int DROP_W    = SRC_FRAC_W - DST_FRAC_W
) (
  input  logic [SRC_W-1:0]         word,
  input  bf16_cvt_pkg::cvt_class_t cls,
  output logic [DST_W-1:0]         result
);
  localparam logic [SRC_W-1:0] HALF_LESS_ONE = (SRC_W'(1) << (DROP_W - 1)) - SRC_W'(1);

  logic [SRC_W-1:0] odd_bump;
  logic [SRC_W-1:0] rounded;
  logic [SRC_W-1:0] nan_marked;

  always_comb begin
    // kept LSB added on top of half-minus-one turns a tie into round-up only when odd
    odd_bump   = {{(SRC_W-1){1'b0}}, word[DROP_W]};
    rounded    = word + HALF_LESS_ONE + odd_bump;
    nan_marked = word | ({{(SRC_W-1){1'b0}}, cls.low_nz} << DROP_W);
    result     = cls.special ? nan_marked[SRC_W-1:DROP_W] : rounded[SRC_W-1:DROP_W];
  end
endmodule

// File: rtl/bf16_pipe_reg.sv
module bf16_pipe_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;
  logic             take;

  always_comb begin
    in_ready = out_ready || !full_q;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;

  // R8: an accepted word is presented after the edge
  a_r8_accept_shows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8: a drained stage with nothing new empties
  a_r8_drain_empties: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9: stalled output keeps valid and data
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/f32_to_bf16_conv.sv
module f32_to_bf16_conv #(
  parameter int EXP_W      = bf16_cvt_pkg::EXP_W,
  parameter int SRC_FRAC_W = bf16_cvt_pkg::SRC_FRAC_W,
  parameter int DST_FRAC_W = bf16_cvt_pkg::DST_FRAC_W,
  localparam int SRC_W     = 1 + EXP_W + SRC_FRAC_W,
  localparam int DST_W     = 1 + EXP_W + DST_FRAC_W,
  localparam int DROP_W    = SRC_FRAC_W - DST_FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DST_W-1:0] out_data
);
  bf16_cvt_pkg::cvt_class_t cls;
  logic [DST_W-1:0]         narrow;

  bf16_classify #(
    .EXP_W      (EXP_W),
    .SRC_FRAC_W (SRC_FRAC_W),
    .DROP_W     (DROP_W)
  ) u_classify (
    .word (in_data),
    .cls  (cls)
  );

  bf16_round #(
    .EXP_W      (EXP_W),
    .SRC_FRAC_W (SRC_FRAC_W),
    .DST_FRAC_W (DST_FRAC_W)
  ) u_round (
    .word   (in_data),
    .cls    (cls),
    .result (narrow)
  );

  bf16_pipe_reg #(
    .WIDTH (DST_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (narrow),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  logic accept;
  logic in_all_ones;
  logic in_frac_nz;
  assign accept      = in_valid && in_ready;
  assign in_all_ones = &in_data[SRC_W-2 -: EXP_W];
  assign in_frac_nz  = |in_data[SRC_FRAC_W-1:0];

  // R7: sign survives the conversion
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_data[DST_W-1] == $past(in_data[SRC_W-1])));

  // R5: infinity in, same-signed infinity out
  a_r5_inf_pass: assert property (@(posedge clk) disable iff (rst)
    (accept && in_all_ones && !in_frac_nz) |=>
      (out_data[DST_W-2:0] == {{EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}}));

  // R6: NaN in, NaN out
  a_r6_nan_kept: assert property (@(posedge clk) disable iff (rst)
    (accept && in_all_ones && in_frac_nz) |=>
      ((&out_data[DST_W-2 -: EXP_W]) && (|out_data[DST_FRAC_W-1:0])));

  // R6: quiet bit survives
  a_r6_quiet_kept: assert property (@(posedge clk) disable iff (rst)
    (accept && in_all_ones && in_data[SRC_FRAC_W-1]) |=> out_data[DST_FRAC_W-1]);
endmodule

// File: tb/f32_to_bf16_conv_test.sv
module f32_to_bf16_conv_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int N_DIRECTED = 18;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  f32_to_bf16_conv uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic logic [15:0] ref_conv(logic [31:0] x);
    int unsigned mag;
    int unsigned rem;
    mag = x[30:16];
    rem = x[15:0];
    if (x[30:23] == 8'hFF) begin
      if (rem != 0) mag = mag | 1;
    end else if (rem > 32'h8000 || (rem == 32'h8000 && mag[0])) begin
      mag = mag + 1;
    end
    return {x[31], mag[14:0]};
  endfunction

  function automatic string ref_tag(logic [31:0] x);
    logic [15:0] r;
    r = ref_conv(x);
    if (x[30:0] == 31'd0) return "R7";
    if (x[30:23] == 8'hFF) return (x[22:0] == 23'd0) ? "R5" : "R6";
    if (r[14:7] == 8'hFF) return "R4";
    if (r[14:7] != x[30:23]) return "R3";
    if (x[15:0] == 16'h8000) return "R2";
    return "R1";
  endfunction

  function automatic logic [31:0] directed(int i);
    case (i)
      0:  return 32'h3F80_8000;
      1:  return 32'h3F81_8000;
      2:  return 32'h3F80_8001;
      3:  return 32'h3F80_7FFF;
      4:  return 32'h3FFF_8000;
      5:  return 32'h007F_8000;
      6:  return 32'h7F7F_FFFF;
      7:  return 32'hFF7F_8000;
      8:  return 32'h7F80_0000;
      9:  return 32'hFF80_0000;
      10: return 32'h7FC0_0000;
      11: return 32'h7F80_0001;
      12: return 32'hFF80_FFFF;
      13: return 32'h7FBF_FFFF;
      14: return 32'h0000_0000;
      15: return 32'h8000_0000;
      16: return 32'h8001_8000;
      default: return 32'hBF80_C000;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic step(bit v, logic [31:0] d, bit r);
    bit occupied;
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #1;
    occupied = (exp_q.size() != 0);
    check(out_valid == occupied, "R8", 32'(out_valid), 32'(occupied), "out_valid");
    check(in_ready == (r || !occupied), "R10", 32'(in_ready), 32'(r || !occupied), "in_ready");
    if (out_valid && occupied)
      check(out_data == exp_q[0], tag_q[0], 32'(out_data), 32'(exp_q[0]), "out_data");
    if (out_valid && out_ready && occupied) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_conv(d));
      tag_q.push_back(ref_tag(d));
    end
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    w = $urandom;
    case ($urandom % 8)
      0: w[30:23] = 8'hFF;
      1: w[30:23] = 8'hFE;
      2: w[15:0]  = 16'h8000;
      3: begin w[30:23] = 8'h00; w[22:16] = 7'h7F; end
      4: begin w[30:23] = 8'hFF; w[22:16] = 7'h00; end
      default: ;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R8", 32'(out_valid), 32'd0, "reset out_valid");

    // directed corner cases, with a stall pattern to cover R9
    for (int i = 0; i < N_DIRECTED; i++) begin
      step(1'b1, directed(i), (i % 3) != 2);
      while (!in_ready) step(1'b1, directed(i), 1'b1);
    end
    repeat (3) step(1'b0, 32'h0, 1'b0);
    repeat (3) step(1'b0, 32'h0, 1'b1);

    // random words under random backpressure
    for (int i = 0; i < N_RANDOM; i++) begin
      step(($urandom % 4) != 0, rand_word(), ($urandom % 3) != 0);
    end
    repeat (4) step(1'b0, 32'h0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule